// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides what happens to the program counter and the status word when the execute path raises an exception or an interrupt line is accepted. It owns the program counter, the status word, the 32-bit cause register and two save pairs. Each save pair holds a saved program counter and a saved status word. The first pair is used for an ordinary entry. The second pair is used for an entry that occurs while an earlier one is still being serviced. A third-level fault, raised while the second level is active, cannot be serviced. In that case the block streams a three-word record of the machine state out to memory and then locks up until reset.

Each clock cycle the block accepts at most one event. An exception from the execute path always beats an interrupt. Events are classified as regular, duplexed or fatal from the two pending flags in the status word. A regular or duplexed entry updates every register at one clock edge and raises a one-cycle flush pulse to the fetch logic. A return-from-trap request restores the program counter and status word from whichever pair is active. Outside of events and returns, the execute path can load the program counter and the status word directly. The event strobe, return request and register loads are plain control pins with no handshake: the block acts on them at the edge where they are high.

The fatal record leaves through a valid/ready stream that carries an address and a data word. A word counts as transferred only on a cycle where both valid and ready are high. While ready is low, valid, address and data hold steady. Back-pressure only delays the record; the words and their order stay the same.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the program counter is 0xFFFFFFF0, the cause register is 0x0000FFF0, and the status word is 0x00008000 (only the nested-fault flag, bit 15, set). The flush pulse, dump valid and lock-up are low.
- R2: Status bits used: bit 15 nested-fault pending, bit 14 entry pending, bit 13 address-trap enable, bit 12 interrupt disable, bits 19:16 interrupt level. The request lines are ignored when bit 12, bit 14 or bit 15 is set, and in any cycle where an exception is strobed. In those cases the program counter does not move and no flush pulse follows.
- R3: When interrupts are accepted and several lines are high, the highest-numbered line L wins. The cause becomes 0xFE00 | (L << 4), and the interrupt level field (bits 19:16) becomes L.
- R4: A regular entry happens when bits 14 and 15 are both clear. It writes the cause into cause bits 15:0 and the old program counter and status word into the first save pair, and sets bit 14. The new program counter is 0xFFFF0000 | (cause & 0xFFF0), except that 0xFFFFFF70 becomes 0xFFFFFF60.
- R5: A duplexed entry happens when bit 14 is set and bit 15 is clear. It writes the cause into cause bits 31:16 and the old program counter and status word into the second save pair, sets bit 15, and jumps to 0xFFFFFFD0.
- R6: An event that arrives with bit 15 set is fatal. The dump stream sends three words in this order: (0xFFFF0000 | cause) to address 0, the status word to address 4, and the program counter to address 8. Each word holds under back-pressure. Lock-up then stays high, and all inputs are ignored until reset.
- R7: Every regular or duplexed entry clears bit 13, sets bit 12, and raises the flush pulse for exactly the cycle after the accepting edge.
- R8: An interrupt accepted while the halted input is high saves the program counter plus 2 instead of the program counter.
- R9: A return-from-trap with bit 15 set restores the second save pair; otherwise it restores the first pair. The restored status word is masked with 0x000FF3FF.
- R10: When no event or return is accepted, the program counter and status word loads from the execute path take effect at the edge. A loaded status word is masked with 0x000FF3FF. Priority is event, then return, then loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Exception strobe from execute |
| evt_cause | input | 16 | Exception cause code |
| irq_lines | input | NUM_IRQ (5) | Interrupt request lines, higher index wins |
| cpu_halted | input | 1 | CPU is parked in the halt state |
| rfe_req | input | 1 | Return-from-trap request |
| pc_wr_en | input | 1 | Load program counter from execute |
| pc_wr_data | input | 32 | Program counter load value |
| psw_wr_en | input | 1 | Load status word from execute |
| psw_wr_data | input | 32 | Status word load value |
| pc_q | output | 32 | Current program counter |
| psw_q | output | 32 | Current status word |
| cause_word | output | 32 | Cause register (duplexed high, regular low) |
| save_pc | output | 32 | First-level saved program counter |
| save_psw | output | 32 | First-level saved status word |
| dup_pc | output | 32 | Second-level saved program counter |
| dup_psw | output | 32 | Second-level saved status word |
| flush_taken | output | 1 | One-cycle pulse after an accepted entry |
| locked_up | output | 1 | Fatal fault seen; block frozen |
| dump_valid | output | 1 | Dump word valid |
| dump_ready | input | 1 | Dump sink ready |
| dump_addr | output | 32 | Dump word address |
| dump_data | output | 32 | Dump word data |

## Verification
The bound checker evaluates these properties on every cycle:
- a flush pulse always comes with interrupt disable set, address-trap enable clear and entry pending set;
- a duplexed entry always lands on its fixed vector;
- no entry lands on the redirected vector;
- masked interrupts never produce a flush;
- a stalled dump word holds still;
- a locked block never moves its program counter.

The exact saved values, cause placement, the winner among several request lines, the halt adjustment of the saved counter, and the order and content of the fatal record can only be shown by the bench's scenarios. Those scenarios run directed nested sequences and seeded random entries, and compare the results against values the bench computes itself.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int XLEN = 32;
  localparam int CAUSE_W = 16;

  localparam int PSW_NP = 15;
  localparam int PSW_EP = 14;
  localparam int PSW_AE = 13;
  localparam int PSW_ID = 12;
  localparam int PSW_LVL_LO = 16;
  localparam int LVL_W = 4;

  localparam logic [XLEN-1:0] PSW_MASK  = 32'h000F_F3FF;
  localparam logic [XLEN-1:0] RESET_PC  = 32'hFFFF_FFF0;
  localparam logic [XLEN-1:0] RESET_PSW = 32'h0000_8000;
  localparam logic [XLEN-1:0] RESET_CAUSE = 32'h0000_FFF0;
  localparam logic [XLEN-1:0] DUP_VEC   = 32'hFFFF_FFD0;
  localparam logic [XLEN-1:0] BAD_VEC   = 32'hFFFF_FF70;
  localparam logic [XLEN-1:0] ALT_VEC   = 32'hFFFF_FF60;
  localparam logic [CAUSE_W-1:0] IRQ_CAUSE_BASE = 16'hFE00;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_REG   = 2'd1,
    EV_DUP   = 2'd2,
    EV_FATAL = 2'd3
  } ev_kind_e;

  function automatic logic [XLEN-1:0] reg_vector(input logic [CAUSE_W-1:0] c);
    logic [XLEN-1:0] v;
    v = {16'hFFFF, c[15:4], 4'h0};
    if (v == BAD_VEC) v = ALT_VEC;
    return v;
  endfunction
endpackage

// File: rtl/exc_irq_prio.sv
module exc_irq_prio
  import exc_seq_pkg::*;
#(
  parameter int NUM_IRQ = 5
) (
  input  logic [NUM_IRQ-1:0]  lines,
  input  logic                blocked,
  output logic                take,
  output logic [LVL_W-1:0]    level,
  output logic [CAUSE_W-1:0]  cause
);
  always_comb begin
    level = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (lines[i]) level = LVL_W'(i);
    end
  end

  assign take  = (|lines) && !blocked;
  assign cause = IRQ_CAUSE_BASE | {8'h00, level, 4'h0};
endmodule

// File: rtl/exc_classify.sv
module exc_classify
  import exc_seq_pkg::*;
(
  input  logic                evt_valid,
  input  logic [CAUSE_W-1:0]  evt_cause,
  input  logic                irq_take,
  input  logic [CAUSE_W-1:0]  irq_cause,
  input  logic                np_flag,
  input  logic                ep_flag,
  output ev_kind_e            kind,
  output logic                from_irq,
  output logic [CAUSE_W-1:0]  cause,
  output logic [XLEN-1:0]     vector
);
  logic any_evt;

  assign any_evt  = evt_valid || irq_take;
  assign from_irq = !evt_valid && irq_take;
  assign cause    = evt_valid ? evt_cause : irq_cause;

  always_comb begin
    if (!any_evt)     kind = EV_NONE;
    else if (np_flag) kind = EV_FATAL;
    else if (ep_flag) kind = EV_DUP;
    else              kind = EV_REG;
  end

  assign vector = (kind == EV_DUP) ? DUP_VEC : reg_vector(cause);
endmodule

// File: rtl/exc_dump_port.sv
module exc_dump_port
  import exc_seq_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int ADDR_STRIDE = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NUM_WORDS*XLEN-1:0] words,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [XLEN-1:0]           out_addr,
  output logic [XLEN-1:0]           out_data
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  logic [XLEN-1:0] store [NUM_WORDS];
  logic [IDX_W-1:0] idx;
  logic busy;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)     store[g] <= '0;
      else if (start) store[g] <= words[g*XLEN +: XLEN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && out_ready) begin
      if (idx == LAST) busy <= 1'b0;
      else             idx  <= idx + 1'b1;
    end
  end

  assign out_valid = busy;
  assign out_addr  = XLEN'(idx) * XLEN'(ADDR_STRIDE);
  assign out_data  = store[idx];
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int NUM_IRQ = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_valid,
  input  logic [15:0]         evt_cause,
  input  logic [NUM_IRQ-1:0]  irq_lines,
  input  logic                cpu_halted,
  input  logic                rfe_req,
  input  logic                pc_wr_en,
  input  logic [31:0]         pc_wr_data,
  input  logic                psw_wr_en,
  input  logic [31:0]         psw_wr_data,
  output logic [31:0]         pc_q,
  output logic [31:0]         psw_q,
  output logic [31:0]         cause_word,
  output logic [31:0]         save_pc,
  output logic [31:0]         save_psw,
  output logic [31:0]         dup_pc,
  output logic [31:0]         dup_psw,
  output logic                flush_taken,
  output logic                locked_up,
  output logic                dump_valid,
  input  logic                dump_ready,
  output logic [31:0]         dump_addr,
  output logic [31:0]         dump_data
);
  localparam int DUMP_WORDS = 3;

  logic               irq_blocked, irq_take, from_irq;
  logic [LVL_W-1:0]   irq_level;
  logic [CAUSE_W-1:0] irq_cause, ev_cause;
  logic [XLEN-1:0]    ev_vector, pc_saved, psw_entry;
  ev_kind_e           ev_kind;
  logic               fatal_start;
  logic [DUMP_WORDS*XLEN-1:0] dump_words;

  assign irq_blocked = evt_valid || locked_up || psw_q[PSW_ID] ||
                       psw_q[PSW_EP] || psw_q[PSW_NP];

  exc_irq_prio #(.NUM_IRQ(NUM_IRQ)) i_prio (
    .lines   (irq_lines),
    .blocked (irq_blocked),
    .take    (irq_take),
    .level   (irq_level),
    .cause   (irq_cause)
  );

  exc_classify i_class (
    .evt_valid (evt_valid),
    .evt_cause (evt_cause),
    .irq_take  (irq_take),
    .irq_cause (irq_cause),
    .np_flag   (psw_q[PSW_NP]),
    .ep_flag   (psw_q[PSW_EP]),
    .kind      (ev_kind),
    .from_irq  (from_irq),
    .cause     (ev_cause),
    .vector    (ev_vector)
  );

  // Saved counter skips past a halt when an interrupt wakes the CPU (R8)
  assign pc_saved = (from_irq && cpu_halted) ? pc_q + 32'd2 : pc_q;

  // Status word after an accepted entry (R3, R4, R5, R7)
  always_comb begin
    psw_entry = psw_q;
    psw_entry[PSW_AE] = 1'b0;
    psw_entry[PSW_ID] = 1'b1;
    if (ev_kind == EV_DUP) psw_entry[PSW_NP] = 1'b1;
    else                   psw_entry[PSW_EP] = 1'b1;
    if (from_irq) psw_entry[PSW_LVL_LO +: LVL_W] = irq_level;
  end

  assign fatal_start = !locked_up && (ev_kind == EV_FATAL);
  assign dump_words  = {pc_q, psw_q, {16'hFFFF, ev_cause}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q        <= RESET_PC;
      psw_q       <= RESET_PSW;
      cause_word  <= RESET_CAUSE;
      save_pc     <= '0;
      save_psw    <= '0;
      dup_pc      <= '0;
      dup_psw     <= '0;
      flush_taken <= 1'b0;
      locked_up   <= 1'b0;
    end else begin
      flush_taken <= 1'b0;
      if (!locked_up) begin
        unique case (ev_kind)
          EV_FATAL: locked_up <= 1'b1;
          EV_REG: begin
            cause_word[15:0] <= ev_cause;
            save_pc     <= pc_saved;
            save_psw    <= psw_q;
            psw_q       <= psw_entry;
            pc_q        <= ev_vector;
            flush_taken <= 1'b1;
          end
          EV_DUP: begin
            cause_word[31:16] <= ev_cause;
            dup_pc      <= pc_saved;
            dup_psw     <= psw_q;
            psw_q       <= psw_entry;
            pc_q        <= ev_vector;
            flush_taken <= 1'b1;
          end
          default: begin
            if (rfe_req) begin
              if (psw_q[PSW_NP]) begin
                pc_q  <= dup_pc;
                psw_q <= dup_psw & PSW_MASK;
              end else begin
                pc_q  <= save_pc;
                psw_q <= save_psw & PSW_MASK;
              end
            end else begin
              if (pc_wr_en)  pc_q  <= pc_wr_data;
              if (psw_wr_en) psw_q <= psw_wr_data & PSW_MASK;
            end
          end
        endcase
      end
    end
  end

  exc_dump_port #(.NUM_WORDS(DUMP_WORDS), .ADDR_STRIDE(4)) i_dump (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fatal_start),
    .words     (dump_words),
    .out_valid (dump_valid),
    .out_ready (dump_ready),
    .out_addr  (dump_addr),
    .out_data  (dump_data)
  );
endmodule

// File: rtl/exc_seq_checker.sv
module exc_seq_checker #(
  parameter int NUM_IRQ = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evt_valid,
  input logic [NUM_IRQ-1:0] irq_lines,
  input logic [31:0]        pc_q,
  input logic [31:0]        psw_q,
  input logic               flush_taken,
  input logic               locked_up,
  input logic               dump_valid,
  input logic               dump_ready,
  input logic [31:0]        dump_addr,
  input logic [31:0]        dump_data
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((|irq_lines) && !evt_valid && (psw_q[12] || psw_q[14] || psw_q[15])) |=> !flush_taken); // R2

  AST_ENTRY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    flush_taken |-> psw_q[14]); // R4

  AST_NO_BAD_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    flush_taken |-> (pc_q != 32'hFFFF_FF70)); // R4

  AST_DUP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_taken && psw_q[15]) |-> (pc_q == 32'hFFFF_FFD0)); // R5

  AST_DUMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_valid && !dump_ready) |=> (dump_valid && $stable(dump_addr) && $stable(dump_data))); // R6

  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    locked_up |=> (locked_up && $stable(pc_q) && !flush_taken)); // R6

  AST_ENTRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_taken |-> (psw_q[12] && !psw_q[13])); // R7
endmodule

bind exc_entry_seq exc_seq_checker #(.NUM_IRQ(NUM_IRQ)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_valid   (evt_valid),
  .irq_lines   (irq_lines),
  .pc_q        (pc_q),
  .psw_q       (psw_q),
  .flush_taken (flush_taken),
  .locked_up   (locked_up),
  .dump_valid  (dump_valid),
  .dump_ready  (dump_ready),
  .dump_addr   (dump_addr),
  .dump_data   (dump_data)
);

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 0, cpu_halted = 0, rfe_req = 0, pc_wr_en = 0, psw_wr_en = 0, dump_ready = 0;
  logic [15:0] evt_cause = 0;
  logic [4:0]  irq_lines = 0;
  logic [31:0] pc_wr_data = 0, psw_wr_data = 0;
  logic [31:0] pc_q, psw_q, cause_word, save_pc, save_psw, dup_pc, dup_psw, dump_addr, dump_data;
  logic flush_taken, locked_up, dump_valid;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic clear_in();
    evt_valid = 0; rfe_req = 0; pc_wr_en = 0; psw_wr_en = 0; irq_lines = 0; cpu_halted = 0;
  endtask

  task automatic load(input logic [31:0] pc, input logic [31:0] psw);
    pc_wr_en = 1; pc_wr_data = pc; psw_wr_en = 1; psw_wr_data = psw;
    tick(); clear_in();
  endtask

  function automatic logic [31:0] m_vec(input logic [15:0] c);
    logic [31:0] v;
    v = {16'hFFFF, c[15:4], 4'h0};
    if (v == 32'hFFFF_FF70) v = 32'hFFFF_FF60;
    return v;
  endfunction

  function automatic logic [31:0] m_psw(input logic [31:0] p, input bit dup,
                                        input bit irq, input logic [3:0] lvl);
    logic [31:0] r;
    r = p | 32'h1000;
    r = r & ~32'h2000;
    r = dup ? (r | 32'h8000) : (r | 32'h4000);
    if (irq) r = {r[31:20], lvl, r[15:0]};
    return r;
  endfunction

  function automatic logic [3:0] m_lvl(input logic [4:0] l);
    logic [3:0] r = 0;
    for (int i = 0; i < 5; i++) if (l[i]) r = 4'(i);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] p0, c0, ps;
    logic [15:0] c;
    logic [3:0] lv;
    void'($urandom(32'h5EED_1234));
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    chk("R1 pc", pc_q, 32'hFFFF_FFF0);
    chk("R1 cause", cause_word, 32'h0000_FFF0);
    chk("R1 psw", psw_q, 32'h0000_8000);
    chk("R1 outputs", {29'd0, flush_taken, dump_valid, locked_up}, 32'd0);

    // R10 loads and masking
    load(32'h0000_1000, 32'hFFFF_FFFF);
    chk("R10 psw mask", psw_q, 32'h000F_F3FF);
    chk("R10 pc load", pc_q, 32'h0000_1000);
    load(32'h0000_1000, 32'h0000_2000);

    // R4/R7 regular entry
    evt_valid = 1; evt_cause = 16'hFF90; tick(); clear_in();
    chk("R4 vector", pc_q, 32'hFFFF_FF90);
    chk("R4 save pc", save_pc, 32'h0000_1000);
    chk("R4 save psw", save_psw, 32'h0000_2000);
    chk("R4 cause low", cause_word, 32'h0000_FF90);
    chk("R7 psw flags", psw_q, 32'h0000_5000);
    chk("R7 flush", {31'd0, flush_taken}, 32'd1);
    tick();
    chk("R7 flush one cycle", {31'd0, flush_taken}, 32'd0);

    // R2: irq ignored while entry pending
    irq_lines = 5'b11111; tick(); clear_in();
    chk("R2 masked by pending pc", pc_q, 32'hFFFF_FF90);
    chk("R2 masked by pending flush", {31'd0, flush_taken}, 32'd0);

    // R5 duplexed entry
    evt_valid = 1; evt_cause = 16'hFF80; tick(); clear_in();
    chk("R5 vector", pc_q, 32'hFFFF_FFD0);
    chk("R5 dup pc", dup_pc, 32'hFFFF_FF90);
    chk("R5 dup psw", dup_psw, 32'h0000_5000);
    chk("R5 cause high", cause_word, 32'hFF80_FF90);
    chk("R5 psw", psw_q, 32'h0000_D000);

    // R9 return selects pair
    rfe_req = 1; pc_wr_en = 1; pc_wr_data = 32'hDEAD_0000; tick(); clear_in();
    chk("R9 dup pair pc", pc_q, 32'hFFFF_FF90);
    chk("R9 dup pair psw", psw_q, 32'h0000_5000);
    rfe_req = 1; tick(); clear_in();
    chk("R9 reg pair pc", pc_q, 32'h0000_1000);
    chk("R9 reg pair psw", psw_q, 32'h0000_2000);

    // R4 redirect
    evt_valid = 1; evt_cause = 16'hFF7C; tick(); clear_in();
    chk("R4 redirect", pc_q, 32'hFFFF_FF60);
    rfe_req = 1; tick(); clear_in();

    // R3 priority
    load(32'h0000_2000, 32'h0);
    irq_lines = 5'b01010; tick(); clear_in();
    chk("R3 vector", pc_q, 32'hFFFF_FE30);
    chk("R3 cause", cause_word[15:0], 32'h0000_FE30);
    chk("R3 level psw", psw_q, 32'h0003_5000);

    // R2 masked by interrupt disable
    load(32'h0000_2100, 32'h0000_1000);
    irq_lines = 5'b11111; tick(); clear_in();
    chk("R2 disable pc", pc_q, 32'h0000_2100);
    chk("R2 disable flush", {31'd0, flush_taken}, 32'd0);

    // R2 exception wins over irq
    load(32'h0000_2200, 32'h0);
    irq_lines = 5'b10000; evt_valid = 1; evt_cause = 16'hFFA5; tick(); clear_in();
    chk("R2 exception beats irq", cause_word[15:0], 32'h0000_FFA5);
    chk("R2 exception psw level", psw_q, 32'h0000_5000);

    // R8 halted interrupt
    load(32'h0000_3000, 32'h0);
    irq_lines = 5'b10001; cpu_halted = 1; tick(); clear_in();
    chk("R8 saved pc", save_pc, 32'h0000_3002);
    chk("R8 vector", pc_q, 32'hFFFF_FE40);

    // Random entries
    for (int k = 0; k < 60; k++) begin
      bit use_irq, dup, h;
      logic [4:0] l;
      use_irq = $urandom_range(0, 1) == 1;
      dup = !use_irq && ($urandom_range(0, 1) == 1);
      h = $urandom_range(0, 1) == 1;
      p0 = {$urandom} & 32'hFFFF_FFFE;
      ps = {$urandom} & 32'h000F_33FF;
      if (dup) ps = ps | 32'h4000;
      if (use_irq) ps = ps & ~32'h1000;
      l = 5'($urandom_range(1, 31));
      c = 16'($urandom);
      load(p0, ps);
      if (use_irq) begin irq_lines = l; cpu_halted = h; end
      else begin evt_valid = 1; evt_cause = c; end
      lv = m_lvl(l);
      if (use_irq) c = 16'hFE00 | {8'h0, lv, 4'h0};
      tick(); clear_in();
      c0 = (use_irq && h) ? p0 + 32'd2 : p0;
      if (dup) begin
        chk("R5 rand pc", pc_q, 32'hFFFF_FFD0);
        chk("R5 rand save", dup_pc, c0);
        chk("R5 rand cause", {16'd0, cause_word[31:16]}, {16'd0, c});
      end else begin
        chk("R4 rand pc", pc_q, m_vec(c));
        chk("R4 rand save", save_pc, c0);
        chk("R4 rand cause", {16'd0, cause_word[15:0]}, {16'd0, c});
      end
      chk("R7 rand psw", psw_q, m_psw(ps, dup, use_irq, lv));
      rfe_req = 1; tick(); clear_in();
      chk("R9 rand return", pc_q, c0);
    end

    // R6 fatal dump with back-pressure
    load(32'h0000_4444, 32'h0000_8005);
    evt_valid = 1; evt_cause = 16'h1234; tick(); clear_in();
    chk("R6 locked", {31'd0, locked_up}, 32'd1);
    for (int w = 0; w < 3; w++) begin
      logic [31:0] ea, ed;
      ea = 32'(w * 4);
      ed = (w == 0) ? 32'hFFFF_1234 : (w == 1) ? 32'h0000_8005 : 32'h0000_4444;
      dump_ready = 0; tick();
      chk("R6 valid held", {31'd0, dump_valid}, 32'd1);
      chk("R6 addr", dump_addr, ea);
      chk("R6 data", dump_data, ed);
      dump_ready = 1; tick(); dump_ready = 0;
    end
    chk("R6 dump done", {31'd0, dump_valid}, 32'd0);
    evt_valid = 1; evt_cause = 16'hFF90; pc_wr_en = 1; pc_wr_data = 32'h0; rfe_req = 1; tick(); clear_in();
    chk("R6 frozen pc", pc_q, 32'h0000_4444);
    chk("R6 frozen flush", {31'd0, flush_taken}, 32'd0);
    chk("R6 still locked", {31'd0, locked_up}, 32'd1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule